// File: doc/BRIEF.md
# Page Translation Cache with Range Invalidation

This block holds a small, fully associative set of page translations for each of several cache instances. It sits between address requesters and a page-table walker. A requester presents a virtual page number and receives the physical page number in the same cycle when the page is cached. On a miss the walker fetches the translation and writes it back through the fill port. The fill goes into a free slot when one exists. Otherwise it evicts a slot chosen in rotation.

Software manages the cached contents through a small register file. It first picks the target instances with a select mask. It then writes a page-aligned lower and upper bound. Finally it issues a command word for either a one-cycle flush of everything or an inclusive range scan. The range scan walks the slots one per cycle. While the scan runs, all lookups and fills are held off, so no stale translation can escape. When the scan ends, a sticky completion flag sets. Software polls the flag and clears it by writing zero.

Top module: `xlt_cache`

## Requirements
- R1: A lookup on instance i reports `lk_hit[i]`=1 and that slot's physical page on `lk_ppn` in the same cycle when exactly one valid slot holds the presented page number. With no match it reports `lk_hit[i]`=0.
- R2: A fill writes the lowest-numbered invalid slot of its instance. When every slot is valid, the fill replaces the slot under a per-instance rotating pointer. The pointer starts at 0 after reset and advances by one, with wrap-around, only on such a replacement.
- R3: When more than one valid slot matches a lookup, `lk_multi[i]`=1 together with `lk_hit[i]`=1. Otherwise `lk_multi[i]`=0.
- R4: Register index 0 is the select mask. Bit i targets instance i, and both bits may be set together. Instances that are not selected keep every slot across flushes and range scans.
- R5: Writing 2 to register index 1 clears every slot of the selected instances at that clock edge. It neither asserts busy nor changes the completion flag.
- R6: Writing 1 to register index 1 asserts `inv_busy` for exactly ENTRIES cycles. During those cycles the block clears each slot of the selected instances whose page number lies between the lower and upper bound, both ends included. Every other slot is kept, and a lower bound above the upper bound clears nothing.
- R7: Register index 2 holds the lower bound and index 3 the upper bound. A write stores the address with bits 11:0 forced to zero, and a read returns that masked value.
- R8: Register index 4 reads 1 once a range scan finishes and stays 1 after that. A write of 0 clears it, and a nonzero write leaves it unchanged.
- R9: While `inv_busy` is 1, every lookup reports no hit and no multi-hit, and fills are discarded.
- R10: A register write made while `inv_busy` is 1 is ignored, and so is a command word other than 1 or 2. Register index 1 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | ADDR_W | Register write data |
| cfg_rdata | output | ADDR_W | Register read data for `cfg_addr` |
| inv_busy | output | 1 | Range scan in progress |
| lk_vpn | input | NUM_INST*VPN_W | Lookup page number per instance |
| lk_hit | output | NUM_INST | Lookup hit per instance |
| lk_ppn | output | NUM_INST*PPN_W | Physical page per instance |
| lk_multi | output | NUM_INST | Multi-hit fault per instance |
| fill_en | input | NUM_INST | Fill strobe per instance |
| fill_vpn | input | NUM_INST*VPN_W | Fill page number per instance |
| fill_ppn | input | NUM_INST*PPN_W | Fill physical page per instance |

## Verification
The hardest state to reach is a multi-hit. The fill path never checks for duplicates, so the bench builds one by filling the same page number twice into one instance. A second hard case is traffic that arrives during a range scan. The bench starts a scan and, in the cycles that follow, drives a lookup, a fill, a bound-register write and a flush command, then proves after the scan that none of them took effect. The inclusive bounds are swept over every lower/upper pair across eight resident pages, for each select mask. The bounds carry nonzero offsets within the page to exercise the masking.

// File: rtl/xlt_cache_pkg.sv
package xlt_cache_pkg;

   // register indices on cfg_addr
   typedef enum logic [2:0] {
      REG_SEL  = 3'd0,
      REG_CMD  = 3'd1,
      REG_LO   = 3'd2,
      REG_HI   = 3'd3,
      REG_DONE = 3'd4
   } reg_idx_e;

   // command words
   localparam int unsigned CMD_RANGE = 1;
   localparam int unsigned CMD_ALL   = 2;

endpackage

// File: rtl/xlt_inv_ctrl.sv
module xlt_inv_ctrl
   import xlt_cache_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int PAGE_SH  = 12,
   parameter int NUM_INST = 2,
   parameter int ENTRIES  = 8,
   localparam int VPN_W   = ADDR_W - PAGE_SH,
   localparam int IDX_W   = $clog2(ENTRIES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [2:0]          cfg_addr,
   input  logic [ADDR_W-1:0]   cfg_wdata,
   output logic [NUM_INST-1:0] sel_q,
   output logic [VPN_W-1:0]    lo_vpn,
   output logic [VPN_W-1:0]    hi_vpn,
   output logic                flush_all,
   output logic                busy,
   output logic [IDX_W-1:0]    scan_idx,
   output logic                done_q
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

   logic busy_q;
   logic wr_ok;

   assign wr_ok     = cfg_we && !busy_q;
   assign flush_all = wr_ok && (cfg_addr == REG_CMD) &&
                      (cfg_wdata == ADDR_W'(CMD_ALL));
   assign busy      = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q    <= '0;
         lo_vpn   <= '0;
         hi_vpn   <= '0;
         busy_q   <= 1'b0;
         scan_idx <= '0;
         done_q   <= 1'b0;
      end else if (busy_q) begin
         scan_idx <= scan_idx + 1'b1;
         if (scan_idx == LAST_IDX) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end
      end else if (wr_ok) begin
         case (cfg_addr)
            REG_SEL:  sel_q  <= cfg_wdata[NUM_INST-1:0];
            REG_CMD:  if (cfg_wdata == ADDR_W'(CMD_RANGE)) begin
                         busy_q   <= 1'b1;
                         scan_idx <= '0;
                      end
            REG_LO:   lo_vpn <= cfg_wdata[ADDR_W-1:PAGE_SH];
            REG_HI:   hi_vpn <= cfg_wdata[ADDR_W-1:PAGE_SH];
            REG_DONE: if (cfg_wdata == '0) done_q <= 1'b0;
            default:  ;
         endcase
      end
   end

endmodule

// File: rtl/xlt_bank.sv
module xlt_bank #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [PPN_W-1:0] lk_ppn,
   output logic             lk_multi,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic             flush_all,
   input  logic             scan_en,
   input  logic [IDX_W-1:0] scan_idx,
   input  logic [VPN_W-1:0] lo_vpn,
   input  logic [VPN_W-1:0] hi_vpn,
   input  logic             stall
);

   logic [ENTRIES-1:0] vld;
   logic [VPN_W-1:0]   tag [ENTRIES];
   logic [PPN_W-1:0]   dat [ENTRIES];
   logic [ENTRIES-1:0] match;
   logic [IDX_W-1:0]   rr_q;
   logic [IDX_W-1:0]   free_idx;
   logic               has_free;
   logic [IDX_W-1:0]   victim;
   logic               do_fill;
   logic               in_range;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign match[e] = vld[e] && (tag[e] == lk_vpn);
   end

   always_comb begin
      lk_ppn = '0;
      for (int e = 0; e < ENTRIES; e++)
         if (match[e]) lk_ppn = lk_ppn | dat[e];
   end

   assign lk_hit   = !stall && (match != '0);
   assign lk_multi = !stall && ((match & (match - 1'b1)) != '0);

   always_comb begin
      free_idx = '0;
      for (int e = ENTRIES - 1; e >= 0; e--)
         if (!vld[e]) free_idx = IDX_W'(e);
   end

   assign has_free = (vld != '1);
   assign victim   = has_free ? free_idx : rr_q;
   assign do_fill  = fill_en && !stall;
   assign in_range = vld[scan_idx] && (tag[scan_idx] >= lo_vpn) &&
                     (tag[scan_idx] <= hi_vpn);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld  <= '0;
         rr_q <= '0;
      end else if (flush_all) begin
         vld <= '0;
      end else if (scan_en) begin
         if (in_range) vld[scan_idx] <= 1'b0;
      end else if (do_fill) begin
         vld[victim] <= 1'b1;
         if (!has_free) rr_q <= rr_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_fill && !flush_all && !scan_en) begin
         tag[victim] <= fill_vpn;
         dat[victim] <= fill_ppn;
      end
   end

endmodule

// File: rtl/xlt_cache.sv
module xlt_cache
   import xlt_cache_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int PAGE_SH  = 12,
   parameter int PPN_W    = 20,
   parameter int NUM_INST = 2,
   parameter int ENTRIES  = 8,
   localparam int VPN_W   = ADDR_W - PAGE_SH,
   localparam int IDX_W   = $clog2(ENTRIES)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [2:0]                cfg_addr,
   input  logic [ADDR_W-1:0]         cfg_wdata,
   output logic [ADDR_W-1:0]         cfg_rdata,
   output logic                      inv_busy,
   input  logic [NUM_INST*VPN_W-1:0] lk_vpn,
   output logic [NUM_INST-1:0]       lk_hit,
   output logic [NUM_INST*PPN_W-1:0] lk_ppn,
   output logic [NUM_INST-1:0]       lk_multi,
   input  logic [NUM_INST-1:0]       fill_en,
   input  logic [NUM_INST*VPN_W-1:0] fill_vpn,
   input  logic [NUM_INST*PPN_W-1:0] fill_ppn
);

   if (ADDR_W <= PAGE_SH) begin : g_bad_page
      $error("xlt_cache: ADDR_W must exceed PAGE_SH");
   end
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_depth
      $error("xlt_cache: ENTRIES must be a power of two, at least 2");
   end
   if (NUM_INST < 1 || NUM_INST > ADDR_W) begin : g_bad_inst
      $error("xlt_cache: NUM_INST out of range");
   end

   logic [NUM_INST-1:0] sel_q;
   logic [VPN_W-1:0]    lo_vpn;
   logic [VPN_W-1:0]    hi_vpn;
   logic                flush_all;
   logic [IDX_W-1:0]    scan_idx;
   logic                done_q;

   xlt_inv_ctrl #(
      .ADDR_W   (ADDR_W),
      .PAGE_SH  (PAGE_SH),
      .NUM_INST (NUM_INST),
      .ENTRIES  (ENTRIES)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .sel_q     (sel_q),
      .lo_vpn    (lo_vpn),
      .hi_vpn    (hi_vpn),
      .flush_all (flush_all),
      .busy      (inv_busy),
      .scan_idx  (scan_idx),
      .done_q    (done_q)
   );

   for (genvar i = 0; i < NUM_INST; i++) begin : g_inst
      xlt_bank #(
         .ENTRIES (ENTRIES),
         .VPN_W   (VPN_W),
         .PPN_W   (PPN_W)
      ) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .lk_vpn    (lk_vpn[i*VPN_W +: VPN_W]),
         .lk_hit    (lk_hit[i]),
         .lk_ppn    (lk_ppn[i*PPN_W +: PPN_W]),
         .lk_multi  (lk_multi[i]),
         .fill_en   (fill_en[i]),
         .fill_vpn  (fill_vpn[i*VPN_W +: VPN_W]),
         .fill_ppn  (fill_ppn[i*PPN_W +: PPN_W]),
         .flush_all (flush_all && sel_q[i]),
         .scan_en   (inv_busy && sel_q[i]),
         .scan_idx  (scan_idx),
         .lo_vpn    (lo_vpn),
         .hi_vpn    (hi_vpn),
         .stall     (inv_busy)
      );
   end

   always_comb begin
      cfg_rdata = '0;
      case (cfg_addr)
         REG_SEL:  cfg_rdata[NUM_INST-1:0]      = sel_q;
         REG_LO:   cfg_rdata[ADDR_W-1:PAGE_SH]  = lo_vpn;
         REG_HI:   cfg_rdata[ADDR_W-1:PAGE_SH]  = hi_vpn;
         REG_DONE: cfg_rdata[0]                 = done_q;
         default:  ;
      endcase
   end

endmodule

// File: rtl/xlt_cache_chk.sv
module xlt_cache_chk #(
   parameter int NUM_INST = 2,
   parameter int ENTRIES  = 8,
   parameter int VPN_W    = 20
) (
   input logic                clk,
   input logic                rst_n,
   input logic                inv_busy,
   input logic [NUM_INST-1:0] lk_hit,
   input logic [NUM_INST-1:0] lk_multi,
   input logic                done_q,
   input logic [VPN_W-1:0]    lo_vpn,
   input logic [VPN_W-1:0]    hi_vpn
);

   localparam int CW = $clog2(ENTRIES) + 2;

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_cnt <= '0;
      else if (inv_busy) run_cnt <= run_cnt + 1'b1;
      else               run_cnt <= '0;
   end

   // R9: no hit is reported while a scan runs
   p_stall_no_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      inv_busy |-> (lk_hit == '0));

   // R3: a multi-hit fault always comes with a hit
   p_multi_has_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_multi & ~lk_hit) == '0);

   // R6: the scan lasts exactly one cycle per slot
   p_scan_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(inv_busy) |-> (run_cnt == CW'(ENTRIES)));

   // R8: the completion flag is set when the scan ends
   p_done_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(inv_busy) |-> done_q);

   // R10: bounds do not move while a scan runs
   p_bounds_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      inv_busy |=> ($stable(lo_vpn) && $stable(hi_vpn)));

endmodule

bind xlt_cache xlt_cache_chk #(
   .NUM_INST (NUM_INST),
   .ENTRIES  (ENTRIES),
   .VPN_W    (VPN_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .inv_busy (inv_busy),
   .lk_hit   (lk_hit),
   .lk_multi (lk_multi),
   .done_q   (done_q),
   .lo_vpn   (lo_vpn),
   .hi_vpn   (hi_vpn)
);

// File: tb/xlt_cache_test.sv
module xlt_cache_test;

   localparam int NI = 2;
   localparam int NE = 8;
   localparam int VW = 20;
   localparam int PW = 20;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           cfg_we;
   logic [2:0]     cfg_addr;
   logic [31:0]    cfg_wdata;
   logic [31:0]    cfg_rdata;
   logic           inv_busy;
   logic [NI*VW-1:0] lk_vpn;
   logic [NI-1:0]    lk_hit;
   logic [NI*PW-1:0] lk_ppn;
   logic [NI-1:0]    lk_multi;
   logic [NI-1:0]    fill_en;
   logic [NI*VW-1:0] fill_vpn;
   logic [NI*PW-1:0] fill_ppn;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   bit m_vld [NI][NE];
   int m_tag [NI][NE];
   int m_ppn [NI][NE];
   int m_rr  [NI];

   always #2.5 clk = ~clk;

   xlt_cache uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .inv_busy(inv_busy),
      .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_multi(lk_multi),
      .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn)
   );

   task automatic chk(string req, string what, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cfg_wr(int a, longint d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a[2:0]; cfg_wdata = d[31:0];
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_rd(int a, output longint d);
      cfg_addr = a[2:0];
      #1;
      d = cfg_rdata;
   endtask

   task automatic hw_fill(int i, int v, int p);
      @(negedge clk);
      fill_en[i] = 1'b1;
      fill_vpn[i*VW +: VW] = v[VW-1:0];
      fill_ppn[i*PW +: PW] = p[PW-1:0];
      @(negedge clk);
      fill_en[i] = 1'b0;
   endtask

   task automatic m_fill(int i, int v, int p);
      int slot = -1;
      for (int e = NE - 1; e >= 0; e--) if (!m_vld[i][e]) slot = e;
      if (slot < 0) begin
         slot = m_rr[i];
         m_rr[i] = (m_rr[i] + 1) % NE;
      end
      m_vld[i][slot] = 1'b1; m_tag[i][slot] = v; m_ppn[i][slot] = p;
   endtask

   task automatic fill(int i, int v, int p);
      hw_fill(i, v, p);
      m_fill(i, v, p);
   endtask

   task automatic probe(int i, int v, string req);
      int cnt = 0;
      int pp = 0;
      for (int e = 0; e < NE; e++)
         if (m_vld[i][e] && m_tag[i][e] == v) begin cnt++; pp = m_ppn[i][e]; end
      lk_vpn[i*VW +: VW] = v[VW-1:0];
      #1;
      chk(req, $sformatf("hit inst%0d vpn %0h", i, v), lk_hit[i], cnt > 0);
      chk("R3", $sformatf("multi inst%0d vpn %0h", i, v), lk_multi[i], cnt > 1);
      if (cnt == 1)
         chk("R1", $sformatf("ppn inst%0d vpn %0h", i, v), lk_ppn[i*PW +: PW], pp);
   endtask

   task automatic m_clear(int sel);
      for (int i = 0; i < NI; i++)
         if (sel[i]) for (int e = 0; e < NE; e++) m_vld[i][e] = 1'b0;
   endtask

   task automatic run_range(int sel, longint lo_a, longint hi_a);
      longint d;
      int n = 0;
      cfg_wr(0, sel); cfg_wr(2, lo_a); cfg_wr(3, hi_a); cfg_wr(1, 1);
      while (inv_busy && n < 100) begin n++; @(negedge clk); end
      chk("R6", "busy cycles", n, NE);
      for (int i = 0; i < NI; i++)
         if (sel[i])
            for (int e = 0; e < NE; e++)
               if (m_tag[i][e] >= (lo_a >> 12) && m_tag[i][e] <= (hi_a >> 12))
                  m_vld[i][e] = 1'b0;
      cfg_rd(4, d);
      chk("R8", "done after scan", d, 1);
      cfg_wr(4, 0);
   endtask

   task automatic flush_both();
      cfg_wr(0, 3); cfg_wr(1, 2);
      m_clear(3);
   endtask

   task automatic finish_run();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      longint d;
      rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      lk_vpn = '0; fill_en = '0; fill_vpn = '0; fill_ppn = '0;
      for (int i = 0; i < NI; i++) begin
         m_rr[i] = 0;
         for (int e = 0; e < NE; e++) begin m_vld[i][e] = 0; m_tag[i][e] = 0; m_ppn[i][e] = 0; end
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      for (int a = 0; a < 5; a++) begin
         cfg_rd(a, d);
         chk("R10", $sformatf("reset reg %0d", a), d, 0);
      end
      chk("R9", "reset busy", inv_busy, 0);
      probe(0, 0, "R1"); probe(1, 0, "R1");

      // R1 basic hit and miss, R2 free-slot order and rotation
      fill(0, 'h21, 'h5a5);
      probe(0, 'h21, "R1"); probe(0, 'h22, "R1"); probe(1, 'h21, "R1");
      flush_both();
      for (int k = 0; k < 11; k++) fill(0, 'h100 + k, 'h800 + k * 7);
      for (int k = 0; k < 11; k++) probe(0, 'h100 + k, "R2");
      run_range(1, 'h104 << 12, 'h104 << 12);
      fill(0, 'h111, 'h999);
      fill(0, 'h112, 'h998);
      for (int k = 0; k < 19; k++) probe(0, 'h100 + k, "R2");

      // R3 multi-hit from a duplicate fill
      fill(1, 'h200, 'h1); fill(1, 'h200, 'h2);
      probe(1, 'h200, "R3"); probe(1, 'h201, "R3");

      // R4 / R5 flush only selected instance
      fill(1, 'h300, 'h33);
      cfg_wr(0, 1); cfg_wr(1, 2); m_clear(1);
      chk("R5", "busy after flush", inv_busy, 0);
      cfg_rd(4, d); chk("R5", "done after flush", d, 0);
      probe(0, 'h105, "R5"); probe(1, 'h300, "R4"); probe(1, 'h200, "R4");

      // R10 unknown command
      cfg_wr(0, 3); cfg_wr(1, 3);
      chk("R10", "busy after cmd 3", inv_busy, 0);
      probe(1, 'h300, "R10");
      cfg_rd(1, d); chk("R10", "cmd reads zero", d, 0);

      // R7 masking
      cfg_wr(2, 'h12345fff); cfg_rd(2, d); chk("R7", "lower bound mask", d, 'h12345000);
      cfg_wr(3, 'habcde001); cfg_rd(3, d); chk("R7", "upper bound mask", d, 'habcde000);

      // R8 sticky flag
      run_range(0, 'h999000, 'h999000);
      cfg_wr(1, 1);
      while (inv_busy) @(negedge clk);
      cfg_wr(4, 5); cfg_rd(4, d); chk("R8", "nonzero write keeps flag", d, 1);
      cfg_wr(4, 0); cfg_rd(4, d); chk("R8", "zero write clears flag", d, 0);

      // R9 / R10 traffic during a scan
      cfg_wr(0, 3); cfg_wr(2, 'h999000); cfg_wr(3, 'h999000); cfg_wr(1, 1);
      lk_vpn[VW +: VW] = 'h300; #1;
      chk("R9", "hit during scan", lk_hit[1], 0);
      chk("R9", "busy during scan", inv_busy, 1);
      hw_fill(1, 'h400, 'h44);
      cfg_wr(2, 'h0);
      cfg_wr(1, 2);
      while (inv_busy) @(negedge clk);
      cfg_wr(4, 0);
      cfg_rd(2, d); chk("R10", "bound write during scan", d, 'h999000);
      probe(1, 'h400, "R9"); probe(1, 'h300, "R10"); probe(0, 'h105, "R10");

      // R6 / R4 inclusive range sweep
      for (int sel = 1; sel <= 3; sel++)
         for (int lo = 0; lo < 8; lo++)
            for (int hi = 0; hi < 8; hi++) begin
               flush_both();
               for (int i = 0; i < NI; i++)
                  for (int k = 0; k < 8; k++) fill(i, 'h40 + k, i * 256 + k * 3 + 1);
               run_range(sel, (longint'('h40 + lo) << 12) | 'habc,
                              (longint'('h40 + hi) << 12) | 'h123);
               for (int i = 0; i < NI; i++)
                  for (int k = 0; k < 8; k++) probe(i, 'h40 + k, sel == 3 ? "R6" : "R4");
            end

      finish_run();
   end

endmodule